// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows, one clock edge at a time, the operating state of a single-data-rate SDRAM as the clock-enable pin would set it. On every edge it looks at three things: the clock-enable level sampled on the previous edge, which it keeps itself, the level on the present edge, and a decoded command. A bank-activity input tells it whether all banks are idle or a read/write burst is running. From these it reports one of six modes, a one-cycle violation pulse, and a ready signal that says whether an ordinary command may be issued on the next edge.

When the device leaves self refresh, the tracker times a recovery window of `EXIT_CYCLES` edges. Only no-operation commands are allowed inside that window, and at least two of them must appear. Ready stays low until the window closes. Sitting beside a memory controller, the tracker lets the controller's command stream be checked against the clock-enable rules, and it can gate command issue on ready.

Encodings: cmd `00` = inhibit/NOP, `01` = auto refresh, `10`/`11` = any other valid command. mode `0` = idle, `1` = burst, `2` = power-down, `3` = self refresh, `4` = clock suspend, `5` = self-refresh exit window.

Top module: `sdram_cke_tracker`

## Requirements
- R1: Synchronous active-high reset gives mode 0 (idle), ready 1 and violation 0, and sets the stored previous clock-enable level to high.
- R2: With clock-enable low on both the previous and current edge, modes 2, 3 and 4 are held whatever the command, and no violation is raised.
- R3: A low-to-high clock-enable edge in mode 2 or 3 with a command other than NOP (cmd != 00) raises the violation, and the mode is unchanged.
- R4: A low-to-high edge in mode 2 with cmd 00 gives mode 0 and ready 1 right after that edge, so a command is accepted on the next edge.
- R5: A low-to-high edge in mode 3 with cmd 00 gives mode 5 with ready 0. Exactly `EXIT_CYCLES` further edges later the mode becomes 0 and ready returns to 1.
- R6: Inside the exit window, any edge that is not high/high with cmd 00 raises the violation. On the last edge of the window, the violation is also raised if fewer than two NOP commands were seen across the window's edges.
- R7: A high-to-low edge in mode 0 gives mode 2 for cmd 00 and mode 3 for cmd 01. For cmd 10 or 11 it raises the violation, and the mode stays 0.
- R8: A high-to-low edge in mode 1 gives mode 4 for any command. A low-to-high edge in mode 4 gives mode 1 with ready 1.
- R9: With clock-enable high on both edges in mode 0 or 1, the next mode is 1 when the burst input is 1 and 0 otherwise.
- R10: Every other combination raises the violation and leaves the mode unchanged. Examples are low/low or low/high in mode 0, and high/low or high/high in mode 2.
- R11: The violation output is a one-cycle pulse, visible in the cycle after the offending edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ckeIn | input | 1 | Clock-enable level sampled on this edge |
| cmdIn | input | 2 | Decoded command (00 NOP, 01 auto refresh, 1x other) |
| burstActive | input | 1 | 1 while a read/write burst runs, 0 when all banks idle |
| mode | output | 3 | Current operating mode (encoding above) |
| violation | output | 1 | One-cycle pulse after an illegal edge |
| ready | output | 1 | High when an ordinary command may be issued next edge |

## Verification
The closing edge of the self-refresh exit window is the edge where two functions meet. On that edge the mode leaves the window and ready returns, and the NOP-count check can raise the violation. The bench provokes this by issuing other commands on the early window edges and a NOP on the last one. That last command is legal by itself, so any violation seen after it must come from the NOP shortfall. The bench requires that pulse and the return to idle with ready high in the same cycle. A run with only NOPs must close the window with no pulse at all.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_BURST   = 3'd1,
    MODE_PWRDN   = 3'd2,
    MODE_SELFREF = 3'd3,
    MODE_SUSPEND = 3'd4,
    MODE_SREXIT  = 3'd5
  } ckeMode_t;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_AREF  = 2'd1,
    CMD_RW    = 2'd2,
    CMD_OTHER = 2'd3
  } ckeCmd_t;

  // strobes from control to the exit-window datapath
  typedef struct packed {
    logic loadTimer;
    logic tickTimer;
    logic nopSeen;
  } timerCtl_t;

endpackage

// File: rtl/sdram_cke_timer.sv
module sdram_cke_timer
  import sdram_cke_pkg::*;
#(
  parameter int EXIT_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  timerCtl_t ctl,
  output logic      windowLast,
  output logic      nopShort
);

  localparam int CW = $clog2(EXIT_CYCLES + 1);

  logic [CW-1:0] remaining;
  logic [1:0]    nopCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      nopCnt    <= 2'd0;
    end else if (ctl.loadTimer) begin
      remaining <= CW'(EXIT_CYCLES);
      nopCnt    <= 2'd0;
    end else if (ctl.tickTimer) begin
      if (remaining != '0) remaining <= remaining - CW'(1);
      if (ctl.nopSeen && nopCnt != 2'd2) nopCnt <= nopCnt + 2'd1;
    end
  end

  assign windowLast = (remaining == CW'(1));
  assign nopShort   = (nopCnt == 2'd0) || ((nopCnt == 2'd1) && !ctl.nopSeen);

  // R5: window length loaded on the exit edge
  a_r5_window_load: assert property (@(posedge clk) disable iff (rst)
    ctl.loadTimer |=> remaining == CW'(EXIT_CYCLES));

  // R5: each window edge consumes one count
  a_r5_window_tick: assert property (@(posedge clk) disable iff (rst)
    (ctl.tickTimer && !ctl.loadTimer && remaining != '0) |=> remaining == $past(remaining) - CW'(1));

  initial begin
    a_r5_min_window: assert (EXIT_CYCLES >= 2);
  end

endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
  import sdram_cke_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ckeIn,
  input  logic [1:0] cmdIn,
  input  logic      burstActive,
  input  logic      windowLast,
  input  logic      nopShort,
  output timerCtl_t ctl,
  output logic [2:0] mode,
  output logic      violation,
  output logic      ready
);

  ckeMode_t state, stateNext;
  logic     ckePrev;
  logic     badEdge;
  logic     isNop, isAref;

  assign isNop  = (cmdIn == CMD_NOP);
  assign isAref = (cmdIn == CMD_AREF);

  always_comb begin
    stateNext = state;
    badEdge   = 1'b0;
    unique case (state)
      MODE_IDLE, MODE_BURST: begin
        unique case ({ckePrev, ckeIn})
          2'b11: stateNext = burstActive ? MODE_BURST : MODE_IDLE;
          2'b10: begin
            if (state == MODE_BURST) stateNext = MODE_SUSPEND;
            else if (isNop)          stateNext = MODE_PWRDN;
            else if (isAref)         stateNext = MODE_SELFREF;
            else                     badEdge   = 1'b1;
          end
          default: badEdge = 1'b1;
        endcase
      end
      MODE_PWRDN, MODE_SELFREF: begin
        unique case ({ckePrev, ckeIn})
          2'b00: stateNext = state;
          2'b01: begin
            if (!isNop)                  badEdge   = 1'b1;
            else if (state == MODE_PWRDN) stateNext = MODE_IDLE;
            else                         stateNext = MODE_SREXIT;
          end
          default: badEdge = 1'b1;
        endcase
      end
      MODE_SUSPEND: begin
        unique case ({ckePrev, ckeIn})
          2'b00: stateNext = state;
          2'b01: stateNext = MODE_BURST;
          default: badEdge = 1'b1;
        endcase
      end
      MODE_SREXIT: begin
        if (!(ckePrev && ckeIn && isNop)) badEdge = 1'b1;
        if (windowLast) begin
          stateNext = MODE_IDLE;
          if (nopShort) badEdge = 1'b1;
        end
      end
      default: begin
        stateNext = MODE_IDLE;
        badEdge   = 1'b1;
      end
    endcase
  end

  always_comb begin
    ctl.loadTimer = (state == MODE_SELFREF) && (stateNext == MODE_SREXIT);
    ctl.tickTimer = (state == MODE_SREXIT);
    ctl.nopSeen   = (state == MODE_SREXIT) && ckePrev && ckeIn && isNop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MODE_IDLE;
      ckePrev   <= 1'b1;
      violation <= 1'b0;
    end else begin
      state     <= stateNext;
      ckePrev   <= ckeIn;
      violation <= badEdge;
    end
  end

  assign mode  = state;
  assign ready = (state == MODE_IDLE) || (state == MODE_BURST);

  // R2: low/low holds the low-power modes
  a_r2_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!ckePrev && !ckeIn && (state == MODE_PWRDN || state == MODE_SELFREF || state == MODE_SUSPEND))
    |=> ($stable(state) && !violation));

  // R4: power-down exit ready on the next edge
  a_r4_pd_exit: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_PWRDN && !ckePrev && ckeIn && isNop) |=> (state == MODE_IDLE && ready));

  // R5: self-refresh exit enters the window with ready low
  a_r5_sr_exit: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_SELFREF && !ckePrev && ckeIn && isNop) |=> (state == MODE_SREXIT && !ready));

  // R7: auto refresh on a falling edge from idle enters self refresh
  a_r7_sr_entry: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_IDLE && ckePrev && !ckeIn && isAref) |=> state == MODE_SELFREF);

  // R8: falling edge during a burst suspends the clock
  a_r8_suspend: assert property (@(posedge clk) disable iff (rst)
    (state == MODE_BURST && ckePrev && !ckeIn) |=> state == MODE_SUSPEND);

  // R10: a flagged edge outside the exit window leaves the mode unchanged
  a_r10_hold_on_bad: assert property (@(posedge clk) disable iff (rst)
    (badEdge && state != MODE_SREXIT) |=> (violation && $stable(state)));

endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker
  import sdram_cke_pkg::*;
#(
  parameter int EXIT_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ckeIn,
  input  logic [1:0] cmdIn,
  input  logic       burstActive,
  output logic [2:0] mode,
  output logic       violation,
  output logic       ready
);

  timerCtl_t timerCtl;
  logic      windowLast;
  logic      nopShort;

  sdram_cke_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ckeIn       (ckeIn),
    .cmdIn       (cmdIn),
    .burstActive (burstActive),
    .windowLast  (windowLast),
    .nopShort    (nopShort),
    .ctl         (timerCtl),
    .mode        (mode),
    .violation   (violation),
    .ready       (ready)
  );

  sdram_cke_timer #(
    .EXIT_CYCLES (EXIT_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .ctl        (timerCtl),
    .windowLast (windowLast),
    .nopShort   (nopShort)
  );

endmodule

// File: tb/sdram_cke_tracker_test.sv
module sdram_cke_tracker_test;

  localparam int EXIT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ckeIn = 1'b1;
  logic [1:0] cmdIn = 2'd0;
  logic       burstActive = 1'b0;
  logic [2:0] mode;
  logic       violation;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sdram_cke_tracker #(.EXIT_CYCLES(EXIT)) uut (
    .clk(clk), .rst(rst), .ckeIn(ckeIn), .cmdIn(cmdIn),
    .burstActive(burstActive), .mode(mode), .violation(violation), .ready(ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect3(input string req, input int m, input int v, input int r);
    chk(req, "mode", int'(mode), m);
    chk(req, "violation", int'(violation), v);
    chk(req, "ready", int'(ready), r);
  endtask

  // apply inputs before an edge, then sample just after it
  task automatic step(input logic cke, input logic [1:0] cmd, input logic burst);
    @(negedge clk);
    ckeIn = cke; cmdIn = cmd; burstActive = burst;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; ckeIn = 1'b1; cmdIn = 2'd0; burstActive = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    expect3("R1", 0, 0, 1);
    // previous level was cleared to high: a falling edge enters power-down
    step(1'b0, 2'd0, 1'b0);
    expect3("R1", 2, 0, 0);
  endtask

  task automatic testPowerDown();
    doReset();
    step(1'b0, 2'd0, 1'b0); expect3("R7", 2, 0, 0);
    step(1'b0, 2'd2, 1'b0); expect3("R2", 2, 0, 0);
    step(1'b1, 2'd3, 1'b0); expect3("R3", 2, 1, 0);
    step(1'b0, 2'd0, 1'b0); expect3("R10", 2, 1, 0);
    step(1'b0, 2'd0, 1'b0); expect3("R11", 2, 0, 0);
    step(1'b1, 2'd0, 1'b0); expect3("R4", 0, 0, 1);
    step(1'b1, 2'd2, 1'b0); expect3("R4", 0, 0, 1);
  endtask

  task automatic testSelfRefresh();
    doReset();
    step(1'b0, 2'd1, 1'b0); expect3("R7", 3, 0, 0);
    step(1'b0, 2'd3, 1'b0); expect3("R2", 3, 0, 0);
    step(1'b1, 2'd0, 1'b0); expect3("R5", 5, 0, 0);
    for (int i = 1; i < EXIT; i++) begin
      step(1'b1, 2'd0, 1'b0); expect3("R5", 5, 0, 0);
    end
    step(1'b1, 2'd0, 1'b0); expect3("R5", 0, 0, 1);
  endtask

  task automatic testNopShortfall();
    doReset();
    step(1'b0, 2'd1, 1'b0);
    step(1'b1, 2'd2, 1'b0); expect3("R3", 3, 1, 0);
    step(1'b1, 2'd0, 1'b0); expect3("R10", 3, 1, 0);
    step(1'b0, 2'd0, 1'b0);
    step(1'b0, 2'd0, 1'b0); expect3("R2", 3, 0, 0);
    step(1'b1, 2'd0, 1'b0); expect3("R5", 5, 0, 0);
    for (int i = 1; i < EXIT; i++) begin
      step(1'b1, 2'd2, 1'b0); expect3("R6", 5, 1, 0);
    end
    // last window edge carries a NOP: only the shortfall can flag it
    step(1'b1, 2'd0, 1'b0); expect3("R6", 0, 1, 1);
    step(1'b1, 2'd0, 1'b0); expect3("R11", 0, 0, 1);
  endtask

  task automatic testSuspend();
    doReset();
    step(1'b1, 2'd2, 1'b1); expect3("R9", 1, 0, 1);
    step(1'b0, 2'd2, 1'b1); expect3("R8", 4, 0, 0);
    step(1'b0, 2'd1, 1'b1); expect3("R2", 4, 0, 0);
    step(1'b1, 2'd3, 1'b1); expect3("R8", 1, 0, 1);
    step(1'b1, 2'd0, 1'b0); expect3("R9", 0, 0, 1);
    step(1'b1, 2'd2, 1'b1); expect3("R9", 1, 0, 1);
  endtask

  task automatic testIllegalIdle();
    doReset();
    step(1'b0, 2'd2, 1'b0); expect3("R7", 0, 1, 1);
    step(1'b0, 2'd0, 1'b0); expect3("R10", 0, 1, 1);
    step(1'b1, 2'd0, 1'b0); expect3("R10", 0, 1, 1);
    step(1'b1, 2'd0, 1'b0); expect3("R11", 0, 0, 1);
  endtask

  initial begin
    testReset();
    testPowerDown();
    testSelfRefresh();
    testNopShortfall();
    testSuspend();
    testIllegalIdle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule